// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. An external baud generator supplies a one-cycle oversample tick. The receiver counts 16 ticks per bit, or 8 ticks when double speed is selected. It confirms a start bit at mid-bit and takes each bit by majority vote of three samples around the bit centre. The character length, the parity mode and an address-filtering mode are set by static configuration inputs.

A finished character waits in a one-character holding stage and then enters a two-entry buffer. Each entry keeps its own framing, parity and overrun flags. A read port always shows the oldest entry. A one-cycle pop pulse removes that entry, with its ninth bit and all of its flags. The ninth bit is shown on its own pin, so it can be read before the pop.

When the receiver is disabled, the buffer and the holding stage are emptied, so every per-character flag goes away with them.

Top module: `serial_rx_core`

## Requirements
- R1: `rd_valid` is high exactly when the buffer holds at least one unread character. It is low after reset. A `rd_pop` while the buffer is empty has no effect.
- R2: `len_code` sets the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. Every other code gives 8. Data arrives LSB first. The character is right-aligned on {`rd_bit9`,`rd_data`}, with the unused upper bits at zero.
- R3: `par_mode` 00 means no parity bit and 01 is treated the same way. With 10, the data bits plus the parity bit must hold an even number of ones. With 11, they must hold an odd number. A mismatch sets `rd_perr` for that character only.
- R4: `rd_ferr` is set for a character whose first stop bit is sampled as 0. No second stop bit is checked, so a new start bit may follow the first stop bit at once.
- R5: The buffer holds two characters in arrival order. Each entry keeps its own flags until it is popped.
- R6: Overrun case: both buffer entries are full, a character waits in the holding stage, and a new start bit is confirmed. Then the waiting character gets its `rd_ovr` flag, and the incoming frame is discarded.
- R7: `rd_bit9` belongs to the entry shown at the head and stays valid until the pop. One `rd_pop` removes the whole entry.
- R8: When `addr_mode` is 1, a frame is kept only if its most significant data bit is 1. In 9-bit mode that is the ninth bit. Other frames are dropped.
- R9: While `rx_en` is 0, the buffer and the holding stage are empty and incoming frames are ignored. After `rx_en` returns to 1, the buffer starts empty.
- R10: A bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when it is 1. Each bit value is the majority of three centre samples, so a line glitch one tick wide does not change the character.
- R11: A low pulse that has ended before the middle of the start bit is a false start. It produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes all stored state |
| os_tick | input | 1 | One-cycle oversample tick from the baud generator |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| len_code | input | 3 | Character length code |
| par_mode | input | 2 | Parity mode code |
| addr_mode | input | 1 | Keep only frames marked as addresses |
| rxd | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Buffer holds an unread character |
| rd_data | output | 8 | Low 8 bits of the head character |
| rd_bit9 | output | 1 | Ninth bit of the head character |
| rd_ferr | output | 1 | Frame error of the head character |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ovr | output | 1 | Overrun flag of the head character |

## Verification
Some rules are checked by the assertions on every cycle:
- the buffer never takes a push while full and never holds more than two entries;
- popping the last entry empties the buffer;
- a disabled receiver holds nothing;
- a start confirmed while both stores are full marks the waiting character;
- a frame completion always returns the bit engine to idle.

Other behaviour can only be shown by the bench's frame scenarios: the bit order and alignment for each length code, the parity and framing checks, how a glitch or a short false start is rejected, address filtering, and the order in which characters leave after an overrun. For these, the bench keeps its own model of the buffer and of the holding stage and compares the head entry with it after every frame and every pop.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned MAX_BITS = 9;

  typedef struct packed {
    logic                ovr;
    logic                perr;
    logic                ferr;
    logic [MAX_BITS-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Number of data bits selected by the length code; unlisted codes fall back to 8.
  function automatic logic [3:0] char_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // Parity bit the sender must transmit for the given (zero-extended) data.
  function automatic logic parity_bit(input logic [MAX_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Bits were shifted in at the top; move the character down to bit 0.
  function automatic logic [MAX_BITS-1:0] align_char(input logic [MAX_BITS-1:0] sh,
                                                     input logic [3:0] n);
    return sh >> (4'(MAX_BITS) - n);
  endfunction

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR_NORMAL  = 16,
  parameter int unsigned OSR_FAST    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      tick,
  input  logic      fast,
  input  logic [2:0] len_code,
  input  logic [1:0] par_mode,
  input  logic      rxd,
  output logic      start_ok,
  output logic      done,
  output rx_entry_t done_entry,
  output logic      done_addr
);
  localparam int unsigned CNTW = $clog2(OSR_NORMAL);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic [1:0]             hist;
  logic [CNTW-1:0]        cnt, osr_last, mid_pt;
  rx_state_t              state;
  logic [3:0]             nbit, nbits, top_idx;
  logic [MAX_BITS-1:0]    shreg, data_al;
  logic                   par_q, par_on, bit_now, decide, wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign nbits    = char_bits(len_code);
  assign top_idx  = nbits - 4'd1;
  assign par_on   = par_mode[1];
  assign osr_last = fast ? CNTW'(OSR_FAST - 1) : CNTW'(OSR_NORMAL - 1);
  assign mid_pt   = fast ? CNTW'(OSR_FAST / 2 + 1) : CNTW'(OSR_NORMAL / 2 + 1);
  assign bit_now  = vote3({hist, rx_s});
  assign decide   = tick && (state != ST_IDLE) && (cnt == mid_pt);
  assign wrap     = tick && (cnt == osr_last);
  assign start_ok = decide && (state == ST_START) && !bit_now;
  assign data_al  = align_char(shreg, nbits);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      hist       <= '1;
      nbit       <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      done       <= 1'b0;
      done_entry <= '0;
      done_addr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        hist <= {hist[0], rx_s};
        if (state != ST_IDLE) cnt <= wrap ? '0 : cnt + 1'b1;
        case (state)
          ST_IDLE: if (!rx_s) begin
            state <= ST_START;
            cnt   <= CNTW'(1);
            nbit  <= '0;
          end
          ST_START: begin
            if (decide && bit_now) state <= ST_IDLE;
            else if (wrap)         state <= ST_DATA;
          end
          ST_DATA: begin
            if (decide) begin
              shreg <= {bit_now, shreg[MAX_BITS-1:1]};
              nbit  <= nbit + 4'd1;
            end
            if (wrap && nbit == nbits) state <= par_on ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            if (decide) par_q <= bit_now;
            if (wrap)   state <= ST_STOP;
          end
          ST_STOP: if (decide) begin
            state           <= ST_IDLE;
            done            <= 1'b1;
            done_entry.data <= data_al;
            done_entry.ferr <= !bit_now;
            done_entry.perr <= par_on && (par_q != parity_bit(data_al, par_mode[0]));
            done_entry.ovr  <= 1'b0;
            done_addr       <= data_al[top_idx];
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: the data-bit counter never runs past the selected length
  p_bits_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (nbit <= nbits));

  // R4: a completed frame leaves the bit engine idle, ready for a new start bit
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));

endmodule

// File: rtl/rx_store.sv
module rx_store
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic      full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_entry_t     mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: the writer never offers a character to a full buffer
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: occupancy never exceeds the buffer depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R1: popping the last entry with nothing arriving leaves the buffer empty
  p_last_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(1) && pop && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR_NORMAL  = 16,
  parameter int unsigned OSR_FAST    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEPTH       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       dbl_speed,
  input  logic [2:0] len_code,
  input  logic [1:0] par_mode,
  input  logic       addr_mode,
  input  logic       rxd,
  input  logic       rd_pop,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rd_ferr,
  output logic       rd_perr,
  output logic       rd_ovr
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          start_ok, frm_done, frm_addr, keep, push, store_full;
  rx_entry_t     frm_entry, hold_e, head;
  logic          hold_v;
  logic [CW-1:0] store_cnt;

  rx_deframer #(
    .OSR_NORMAL (OSR_NORMAL),
    .OSR_FAST   (OSR_FAST),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rx_en),
    .tick      (os_tick),
    .fast      (dbl_speed),
    .len_code  (len_code),
    .par_mode  (par_mode),
    .rxd       (rxd),
    .start_ok  (start_ok),
    .done      (frm_done),
    .done_entry(frm_entry),
    .done_addr (frm_addr)
  );

  // Holding stage: the character that waits when the buffer is full.
  assign push = hold_v && !store_full;
  assign keep = frm_done && (!addr_mode || frm_addr);

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      hold_v <= 1'b0;
      hold_e <= '0;
    end else begin
      if (push) hold_v <= 1'b0;
      if (start_ok && hold_v && store_full) hold_e.ovr <= 1'b1;
      if (keep && (!hold_v || push)) begin
        hold_v <= 1'b1;
        hold_e <= frm_entry;
      end
    end
  end

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!rx_en),
    .push      (push),
    .push_entry(hold_e),
    .pop       (rd_pop),
    .head      (head),
    .count     (store_cnt),
    .full      (store_full)
  );

  assign rd_valid = (store_cnt != '0);
  assign rd_data  = head.data[7:0];
  assign rd_bit9  = head.data[8];
  assign rd_ferr  = head.ferr;
  assign rd_perr  = head.perr;
  assign rd_ovr   = head.ovr;

  // R9: a disabled receiver keeps nothing buffered or waiting
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!hold_v && !rd_valid));

  // R6: a start bit arriving with both stores full marks the waiting character
  p_ovr_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && start_ok && hold_v && store_full) |=> hold_e.ovr);

  // R5: a waiting character moves on as soon as the buffer has room
  p_hold_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && hold_v && !store_full && !frm_done) |=> !hold_v);

endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int TICK_DIV = 4;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n, rx_en, os_tick, dbl_speed, addr_mode, rxd, rd_pop;
  logic [2:0] len_code;
  logic [1:0] par_mode;
  logic rd_valid, rd_bit9, rd_ferr, rd_perr, rd_ovr;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int tdiv = 0;

  // model: {ovr, perr, ferr, data[8:0]}
  logic [11:0] mq[$];
  logic [11:0] mhold;
  bit          mhold_v = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv    <= 0;
      os_tick <= 1'b0;
    end else begin
      tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      os_tick <= (tdiv == TICK_DIV - 1);
    end
  end

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick),
    .dbl_speed(dbl_speed), .len_code(len_code), .par_mode(par_mode),
    .addr_mode(addr_mode), .rxd(rxd), .rd_pop(rd_pop), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .rd_perr(rd_perr), .rd_ovr(rd_ovr)
  );

  function automatic int bits_of(input logic [2:0] code);
    if (code == 3'b000) return 5;
    if (code == 3'b001) return 6;
    if (code == 3'b010) return 7;
    if (code == 3'b111) return 9;
    return 8;
  endfunction

  function automatic logic [8:0] mask_of(input logic [8:0] d, input int n);
    logic [8:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = d[i];
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_head(input string req);
    if (mq.size() == 0) check({req, " valid"}, {31'd0, rd_valid}, 32'd0);
    else begin
      check({req, " valid"}, {31'd0, rd_valid}, 32'd1);
      check({req, " entry"}, {20'd0, rd_ovr, rd_perr, rd_ferr, rd_bit9, rd_data}, {20'd0, mq[0]});
    end
  endtask

  task automatic idle_bits(input int k);
    rxd = 1'b1;
    repeat (k * 16 * TICK_DIV) @(negedge clk);
  endtask

  task automatic pop_one;
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    if (mq.size() != 0) begin
      void'(mq.pop_front());
      if (mhold_v) begin
        mq.push_back(mhold);
        mhold_v = 0;
      end
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input logic [2:0] code, input logic [1:0] pm,
                            input bit bad_par, input bit stop_v, input bit dbl, input int gbit);
    int n, bp;
    logic [8:0] dm;
    logic pb;
    n  = bits_of(code);
    bp = (dbl ? 8 : 16) * TICK_DIV;
    dm = mask_of(d, n);
    @(negedge clk);
    dbl_speed = dbl;
    len_code  = code;
    par_mode  = pm;
    if (rx_en && mhold_v && mq.size() == 2) mhold[11] = 1'b1;
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      if (i == gbit) begin
        repeat (bp / 2) @(negedge clk);
        rxd = ~d[i];
        repeat (TICK_DIV) @(negedge clk);
        rxd = d[i];
        repeat (bp / 2 - TICK_DIV) @(negedge clk);
      end else repeat (bp) @(negedge clk);
    end
    if (pm[1]) begin
      pb  = (^dm) ^ pm[0] ^ bad_par;
      rxd = pb;
      repeat (bp) @(negedge clk);
    end
    rxd = stop_v;
    repeat (bp) @(negedge clk);
    rxd = 1'b1;
    if (rx_en && !(addr_mode && !dm[n-1])) begin
      logic [11:0] e;
      e = {1'b0, pm[1] & bad_par, ~stop_v, dm};
      if (mhold_v) begin
      end else if (mq.size() < 2) mq.push_back(e);
      else begin
        mhold   = e;
        mhold_v = 1;
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_en = 1'b1; rxd = 1'b1; rd_pop = 1'b0;
    dbl_speed = 1'b0; len_code = 3'b011; par_mode = 2'b00; addr_mode = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_head("R1 reset empty");

    // R2 / R7: every length code, 9-bit carries bit9 on its own pin
    send_frame(9'h0A5, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R2 8-bit");
    pop_one; check_head("R1 empty after pop");
    pop_one; check_head("R1 pop on empty ignored");
    send_frame(9'h1C3, 3'b111, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R7 9-bit bit9");
    pop_one;
    send_frame(9'h1FF, 3'b000, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R2 5-bit"); pop_one;
    send_frame(9'h16A, 3'b001, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R2 6-bit"); pop_one;
    send_frame(9'h155, 3'b010, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R2 7-bit"); pop_one;
    send_frame(9'h13C, 3'b101, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R2 reserved code as 8-bit"); pop_one;

    // R3 / R5: parity modes, flags kept per entry
    send_frame(9'h0B7, 3'b011, 2'b10, 1, 1, 0, -1); idle_bits(2);
    send_frame(9'h0B7, 3'b011, 2'b10, 0, 1, 0, -1); idle_bits(2);
    check_head("R3 even parity mismatch");
    pop_one; check_head("R5 second entry own flags");
    pop_one;
    send_frame(9'h06E, 3'b011, 2'b11, 0, 1, 0, -1); idle_bits(2);
    check_head("R3 odd parity good"); pop_one;
    send_frame(9'h06E, 3'b011, 2'b11, 1, 1, 1, -1); idle_bits(2);
    check_head("R3 odd parity bad at 8x R10"); pop_one;
    send_frame(9'h033, 3'b011, 2'b01, 1, 1, 0, -1); idle_bits(2);
    check_head("R3 reserved mode no parity"); pop_one;

    // R4: stop bit low, then back-to-back frames after one stop bit
    send_frame(9'h081, 3'b011, 2'b00, 0, 0, 0, -1); idle_bits(2);
    check_head("R4 frame error"); pop_one;
    check_head("R11 trailing low stop made no char");
    send_frame(9'h012, 3'b011, 2'b00, 0, 1, 0, -1);
    send_frame(9'h034, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R4 back-to-back first"); pop_one;
    check_head("R4 back-to-back second"); pop_one;

    // R6: overrun on the waiting character, the fourth frame lost
    send_frame(9'h0A1, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    send_frame(9'h0A2, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    send_frame(9'h0A3, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    send_frame(9'h0A4, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R6 first unflagged"); pop_one;
    check_head("R6 second unflagged"); pop_one;
    check_head("R6 waiting char flagged"); pop_one;
    check_head("R6 fourth frame discarded");

    // R8: address filtering
    addr_mode = 1'b1;
    send_frame(9'h055, 3'b111, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R8 data frame dropped");
    send_frame(9'h1AA, 3'b111, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R8 address frame kept"); pop_one;
    send_frame(9'h07F, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    send_frame(9'h080, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    check_head("R8 8-bit marker"); pop_one;
    check_head("R8 only marked frame stored");
    addr_mode = 1'b0;

    // R10: a one-tick glitch at the bit centre is outvoted
    send_frame(9'h0C6, 3'b011, 2'b00, 0, 1, 0, 2); idle_bits(2);
    check_head("R10 glitch rejected"); pop_one;

    // R11: short low pulse
    @(negedge clk) rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    idle_bits(2);
    check_head("R11 false start ignored");

    // R9: disable flushes and ignores frames
    send_frame(9'h011, 3'b011, 2'b00, 0, 0, 0, -1); idle_bits(2);
    send_frame(9'h022, 3'b011, 2'b10, 1, 1, 0, -1); idle_bits(2);
    check_head("R9 buffered before disable");
    @(negedge clk) rx_en = 1'b0;
    repeat (3) @(negedge clk);
    mq.delete(); mhold_v = 0;
    check_head("R9 flushed");
    send_frame(9'h044, 3'b011, 2'b00, 0, 1, 0, -1); idle_bits(2);
    @(negedge clk) rx_en = 1'b1;
    repeat (3) @(negedge clk);
    check_head("R9 frame ignored while disabled");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int unsigned r;
      logic [2:0] code;
      r = $urandom;
      case (r % 5)
        0: code = 3'b000;
        1: code = 3'b001;
        2: code = 3'b010;
        3: code = 3'b011;
        default: code = 3'b111;
      endcase
      send_frame(r[20:12], code, r[4:3], r[8:6] == 3'd0, r[11:9] != 3'd0, r[5], -1);
      idle_bits(2);
      check_head("R2 R3 R4 R5 random");
      if (r[21]) begin
        pop_one;
        check_head("R5 R6 random after pop");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule